// File: doc/BRIEF.md
# Cell Balancing Time-Slot Scheduler

This block divides time into repeating frames for a multi-cell battery monitor. Each frame opens with a measurement window, during which every balancing switch is held off so the cell voltages settle and the comparators can be read. A balancing window follows, during which at most one cell's bleed switch is turned on. Timing is counted in milliseconds from an external tick. A frame lasts 400 ms in normal operation and 100 ms in quick-test operation. In both modes the measurement window lasts 50 ms.

At the end of each measurement window the block pulses a sample strobe, which the other detectors also use. At that edge it reads two comparator flags per cell. One says the cell is above the balance threshold. The other says it has dropped below the release threshold. Each cell keeps its own qualification counter and its own eligibility bit. A rotating pointer then hands the balancing slot to the next eligible connected cell, counting upward from cell 1 and wrapping after the highest connected cell. Its index is reported on a status output.

Top module: `cbal_sched`

## Requirements
- R1: In normal mode, consecutive `sample_stb` pulses are 400 ms ticks apart. Each pulse comes on the clock edge that ends the 50th tick of the frame.
- R2: In normal mode the selected switch stays on for 350 ms ticks, up to the frame boundary. All switches are off for the whole 50 ms measurement window.
- R3: `quick_req` passes through a two-flop synchronizer and is adopted at the next frame boundary. In quick mode, strobes are 100 ms apart and the balancing window lasts 50 ms.
- R4: `sample_stb` is high for exactly one clock per frame. `bal_det` and `bal_rel` are read only on that edge.
- R5: A cell becomes eligible once `bal_det` has been seen high for `dly_sel`+1 consecutive samples. With `dly_sel`=0, a single sample is enough.
- R6: A sample with that cell's `bal_det` low clears its qualification count.
- R7: `sw_en` has at most one bit set. `act_idx` gives the bit position of the set bit (bit 0 = cell 1). `act_idx` reads 7 when no switch is on.
- R8: Eligible cells are served one per frame. The search runs in ascending order starting after the cell served last. Ineligible cells are skipped, and the search wraps after the highest connected cell. After reset the search starts at cell 1.
- R9: An eligible cell whose `bal_rel` is high at a sample loses its eligibility, and it is not switched on in that frame.
- R10: Cells whose index is `cell_cnt` or higher are never eligible and never switched on.
- R11: When no connected cell is eligible, every switch stays off for the whole frame.
- R12: While reset is applied and right after it, `sw_en`=0, `sample_stb`=0 and `act_idx`=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| cell_cnt | input | 3 | Number of connected cells (1..5) |
| dly_sel | input | 4 | Extra consecutive detect samples needed before a cell qualifies |
| quick_req | input | 1 | Asynchronous level requesting quick-test timing |
| bal_det | input | 5 | Per-cell flag: at or above the balance threshold |
| bal_rel | input | 5 | Per-cell flag: below the release threshold |
| sw_en | output | 5 | Balancing switch enables, at most one set |
| sample_stb | output | 1 | One-clock pulse at the end of the measurement window |
| act_idx | output | 3 | Index of the enabled switch, 7 when none |

## Verification
The assertions assume that `cell_cnt` stays between 1 and 5 and changes only while reset is applied. They also assume that `ms_tick` never pulses on two adjacent clocks. The bench meets both conditions: it programs the cell count and delay only during reset, and it raises the tick once every four clocks. The bench also changes the comparator flags only right after a strobe has been seen. Each flag set is therefore stable for a full frame before it is read.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
  localparam int unsigned CELLS_DEF   = 5;
  localparam int unsigned FRAME_MS    = 400;
  localparam int unsigned QFRAME_MS   = 100;
  localparam int unsigned MEAS_MS     = 50;
  localparam int unsigned DLY_W_DEF   = 4;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_QUICK  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/cbal_timer.sv
module cbal_timer
  import cbal_pkg::*;
#(
  parameter int unsigned NORM_MS = FRAME_MS,
  parameter int unsigned QUICK_MS = QFRAME_MS,
  parameter int unsigned WIN_MS  = MEAS_MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic quick_req,
  output logic meas_end,
  output logic frame_end
);
  localparam int unsigned PH_W = $clog2(NORM_MS);

  logic        sync1_q, sync2_q;
  frame_mode_e mode_q, mode_d;
  logic [PH_W-1:0] phase_q, phase_d, last_ph;

  assign last_ph   = (mode_q == MODE_QUICK) ? PH_W'(QUICK_MS - 1) : PH_W'(NORM_MS - 1);
  assign frame_end = ms_tick && (phase_q == last_ph);
  assign meas_end  = ms_tick && (phase_q == PH_W'(WIN_MS - 1));

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    if (ms_tick) begin
      if (frame_end) begin
        phase_d = '0;
        mode_d  = sync2_q ? MODE_QUICK : MODE_NORMAL;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      mode_q  <= MODE_NORMAL;
      phase_q <= '0;
    end else begin
      sync1_q <= quick_req;
      sync2_q <= sync1_q;
      if (ms_tick) begin
        mode_q  <= mode_d;
        phase_q <= phase_d;
      end
    end
  end
endmodule

// File: rtl/cbal_cell.sv
module cbal_cell #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic             present,
  input  logic             det,
  input  logic             rel,
  input  logic [DLY_W-1:0] dly,
  output logic             elig_nxt,
  output logic             elig
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             elig_q;

  always_comb begin
    cnt_d    = cnt_q;
    elig_nxt = elig_q;
    if (!present) begin
      cnt_d    = '0;
      elig_nxt = 1'b0;
    end else if (smp) begin
      if (elig_q) begin
        if (rel) begin
          elig_nxt = 1'b0;
          cnt_d    = '0;
        end
      end else if (det) begin
        if (cnt_q >= dly) begin
          elig_nxt = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      elig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      elig_q <= elig_nxt;
    end
  end

  assign elig = elig_q;
endmodule

// File: rtl/cbal_rr_pick.sv
module cbal_rr_pick #(
  parameter int unsigned NCELL = 5,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 3
) (
  input  logic [NCELL-1:0] elig,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [CNT_W-1:0] cell_cnt,
  output logic             grant_vld,
  output logic [IDX_W-1:0] grant_idx
);
  localparam int unsigned C_W = (IDX_W > CNT_W) ? IDX_W : CNT_W;

  logic [C_W-1:0] cand;

  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    cand      = C_W'(last_idx);
    for (int k = 0; k < NCELL; k++) begin
      if ({1'b0, cand} + 1'b1 >= {1'b0, C_W'(cell_cnt)}) cand = '0;
      else                                                cand = cand + 1'b1;
      if (!grant_vld && (int'(cand) < NCELL) && elig[cand]) begin
        grant_vld = 1'b1;
        grant_idx = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/cbal_sched.sv
module cbal_sched
  import cbal_pkg::*;
#(
  parameter int unsigned NCELL   = CELLS_DEF,
  parameter int unsigned DLY_W   = DLY_W_DEF,
  parameter int unsigned NORM_MS = FRAME_MS,
  parameter int unsigned QUICK_MS = QFRAME_MS,
  parameter int unsigned WIN_MS  = MEAS_MS,
  localparam int unsigned IDX_W  = $clog2(NCELL + 1),
  localparam int unsigned CNT_W  = $clog2(NCELL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic [CNT_W-1:0] cell_cnt,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             quick_req,
  input  logic [NCELL-1:0] bal_det,
  input  logic [NCELL-1:0] bal_rel,
  output logic [NCELL-1:0] sw_en,
  output logic             sample_stb,
  output logic [IDX_W-1:0] act_idx
);
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  logic             meas_end, frame_end;
  logic [NCELL-1:0] elig_nxt, elig_cur;
  logic             grant_vld;
  logic [IDX_W-1:0] grant_idx;

  logic [NCELL-1:0] sw_q, sw_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic             stb_q;

  cbal_timer #(.NORM_MS(NORM_MS), .QUICK_MS(QUICK_MS), .WIN_MS(WIN_MS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .quick_req (quick_req),
    .meas_end  (meas_end),
    .frame_end (frame_end)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    cbal_cell #(.DLY_W(DLY_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (meas_end),
      .present  (CNT_W'(g) < cell_cnt),
      .det      (bal_det[g]),
      .rel      (bal_rel[g]),
      .dly      (dly_sel),
      .elig_nxt (elig_nxt[g]),
      .elig     (elig_cur[g])
    );
  end

  cbal_rr_pick #(.NCELL(NCELL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
    .elig      (elig_nxt),
    .last_idx  (last_q),
    .cell_cnt  (cell_cnt),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
  );

  always_comb begin
    sw_d   = sw_q;
    idx_d  = idx_q;
    last_d = last_q;
    if (frame_end) begin
      sw_d  = '0;
      idx_d = IDX_NONE;
    end else if (meas_end) begin
      if (grant_vld) begin
        sw_d   = NCELL'(1) << grant_idx;
        idx_d  = grant_idx;
        last_d = grant_idx;
      end else begin
        sw_d  = '0;
        idx_d = IDX_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      idx_q  <= IDX_NONE;
      last_q <= IDX_W'(NCELL - 1);
      stb_q  <= 1'b0;
    end else begin
      stb_q <= meas_end;
      if (frame_end || meas_end) begin
        sw_q   <= sw_d;
        idx_q  <= idx_d;
        last_q <= last_d;
      end
    end
  end

  assign sw_en      = sw_q;
  assign act_idx    = idx_q;
  assign sample_stb = stb_q;
endmodule

// File: rtl/cbal_sched_chk.sv
module cbal_sched_chk #(
  parameter int unsigned NCELL = 5,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cell_cnt,
  input logic [NCELL-1:0] sw_en,
  input logic             sample_stb,
  input logic [IDX_W-1:0] act_idx
);
  // R7
  one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));

  // R7
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en == '0) |-> (act_idx == '1));

  // R7
  busy_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en != '0) |-> ((sw_en >> act_idx) == NCELL'(1)));

  // R10
  cell_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en >> cell_cnt) == '0));

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R2
  meas_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ($past(sw_en) == '0));

  // R8
  grant_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en != '0) && (sw_en != $past(sw_en))) |-> sample_stb);
endmodule

bind cbal_sched cbal_sched_chk #(.NCELL(NCELL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cell_cnt   (cell_cnt),
  .sw_en      (sw_en),
  .sample_stb (sample_stb),
  .act_idx    (act_idx)
);

// File: tb/tb_cbal_sched.sv
module tb_cbal_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick = 1'b0;
  logic [2:0] cell_cnt;
  logic [3:0] dly_sel;
  logic       quick_req;
  logic [4:0] bal_det, bal_rel;
  logic [4:0] sw_en;
  logic       sample_stb;
  logic [2:0] act_idx;
  logic [1:0] div = 2'd0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  cbal_sched dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cell_cnt(cell_cnt),
    .dly_sel(dly_sel), .quick_req(quick_req), .bal_det(bal_det),
    .bal_rel(bal_rel), .sw_en(sw_en), .sample_stb(sample_stb), .act_idx(act_idx)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    div     <= div + 2'd1;
    ms_tick <= (div == 2'd2);
    cyc     <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] cnt, input logic [3:0] dly);
    rst_n = 1'b0; cell_cnt = cnt; dly_sel = dly;
    bal_det = '0; bal_rel = '0; quick_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!sample_stb);
  endtask

  task automatic count_period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cell_cnt = 3'd5; dly_sel = '0;
    bal_det = '1; bal_rel = '0; quick_req = 1'b0;
    repeat (3) @(negedge clk);
    check(sw_en == 0 && sample_stb == 0, "R12 in reset", int'(sw_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(act_idx == 3'd7, "R12 idle index", int'(act_idx), 7);
    check(sw_en == 0, "R12 switches", int'(sw_en), 0);
  endtask

  task automatic t_period();
    int n;
    int on;
    do_reset(3'd5, 4'd0);
    wait_stb();
    @(negedge clk);
    check(sample_stb == 0, "R4 strobe width", int'(sample_stb), 0);
    on = 0;
    n = 1;
    do begin @(negedge clk); n++; if (sw_en != 0) on++; end while (!sample_stb);
    check(n == 1600, "R1 frame period", n, 1600);
    check(on == 0, "R11 no eligible cell", on, 0);
  endtask

  task automatic t_window();
    int on;
    int off;
    do_reset(3'd5, 4'd0);
    bal_det = 5'b00001;
    wait_stb();
    check(sw_en == 5'b00001 && act_idx == 0, "R5 zero delay grant", int'(sw_en), 1);
    on = 0;
    while (sw_en != 0) begin on++; @(negedge clk); end
    check(on == 1400, "R2 balancing length", on, 1400);
    off = 0;
    while (!sample_stb) begin off++; @(negedge clk); end
    check(off == 200, "R2 measurement quiet", off, 200);
  endtask

  task automatic t_rotate();
    int exp_seq[6] = '{0, 1, 2, 3, 4, 0};
    do_reset(3'd5, 4'd0);
    bal_det = 5'b11111;
    for (int i = 0; i < 6; i++) begin
      wait_stb();
      check(act_idx == exp_seq[i] && sw_en == (5'b1 << exp_seq[i]),
            "R8 ascending rotation", int'(act_idx), exp_seq[i]);
    end
  endtask

  task automatic t_skip();
    int exp_seq[3] = '{2, 4, 2};
    do_reset(3'd5, 4'd0);
    bal_det = 5'b10100;
    for (int i = 0; i < 3; i++) begin
      wait_stb();
      check(act_idx == exp_seq[i], "R8 skip ineligible", int'(act_idx), exp_seq[i]);
    end
  endtask

  task automatic t_count3();
    int exp_seq[5] = '{0, 1, 2, 0, 1};
    do_reset(3'd3, 4'd0);
    bal_det = 5'b11111;
    for (int i = 0; i < 5; i++) begin
      wait_stb();
      check(act_idx == exp_seq[i] && sw_en[4:3] == 0, "R10 three cells", int'(act_idx), exp_seq[i]);
    end
  endtask

  task automatic t_delay();
    logic [4:0] pat[6] = '{5'b1, 5'b1, 5'b0, 5'b1, 5'b1, 5'b1};
    do_reset(3'd5, 4'd2);
    bal_det = 5'b00001;
    for (int i = 0; i < 3; i++) begin
      wait_stb();
      check(sw_en == ((i == 2) ? 5'b1 : 5'b0), "R5 delay two", int'(sw_en), (i == 2) ? 1 : 0);
    end
    do_reset(3'd5, 4'd2);
    for (int i = 0; i < 6; i++) begin
      bal_det = pat[i];
      wait_stb();
      check(sw_en == ((i == 5) ? 5'b1 : 5'b0), "R6 count restart", int'(sw_en), (i == 5) ? 1 : 0);
    end
  endtask

  task automatic t_release();
    do_reset(3'd5, 4'd0);
    bal_det = 5'b00011;
    wait_stb();
    check(act_idx == 0, "R9 setup first", int'(act_idx), 0);
    wait_stb();
    check(act_idx == 1, "R9 setup second", int'(act_idx), 1);
    bal_rel = 5'b00001;
    wait_stb();
    check(sw_en == 5'b00010, "R9 released cell skipped", int'(sw_en), 2);
    bal_rel = 5'b00000;
    wait_stb();
    check(sw_en == 5'b00001, "R9 cell requalifies", int'(sw_en), 1);
    do_reset(3'd5, 4'd0);
    bal_det = 5'b00001;
    wait_stb();
    bal_rel = 5'b00001;
    wait_stb();
    check(sw_en == 5'b0 && act_idx == 3'd7, "R9 sole cell released", int'(sw_en), 0);
  endtask

  task automatic t_quick();
    int n;
    int on;
    do_reset(3'd5, 4'd0);
    bal_det = 5'b00001;
    quick_req = 1'b1;
    wait_stb(); wait_stb(); wait_stb();
    count_period(n);
    check(n == 400, "R3 quick period", n, 400);
    on = 0;
    while (sw_en != 0) begin on++; @(negedge clk); end
    check(on == 200, "R3 quick balancing length", on, 200);
    quick_req = 1'b0;
    wait_stb(); wait_stb(); wait_stb();
    count_period(n);
    check(n == 1600, "R3 back to normal", n, 1600);
  endtask

  initial begin
    t_reset();
    t_period();
    t_window();
    t_rotate();
    t_skip();
    t_count3();
    t_delay();
    t_release();
    t_quick();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule